// File: doc/BRIEF.md
# Two-Sided Hardware Semaphore Bank

This block gives two independent agents, called the left and right sides, a small set of binary lock tokens. Each token is separate from any shared storage. Each side asks for a token by writing a zero to it and gives it up by writing a one. Reading the token back tells a side whether it won. Each token keeps one request latch per side. A request from the side that does not hold the token stays pending in its latch. When the holder lets go, the token moves at once to the waiting side. Neither side is ever stalled: contention is resolved entirely inside the bank.

Every access is synchronous to one clock, and each side can issue at most one access per cycle. A side reaches the bank only when its semaphore select is high and its memory enable is low. A read is captured on the clock edge where the read condition first becomes true. The captured value is then frozen until that condition drops, so software that polls a token must toggle its output enable or its select between polls.

Top module: `sem_bank`

## Requirements
- R1: The bank holds `NUM_SEM` (default 8) independent tokens, chosen by the `IDX_W`-bit index of the accessing side. A write changes only the token it indexes.
- R2: A side accesses the bank only in a cycle where its `*_sem_en` is 1 and its `*_mem_en` is 0. In any other cycle, including one where both selects are 1, no request latch and no token changes.
- R3: On a write (`*_wr`=1), the bit `*_wbit` is stored in that side's request latch for the indexed token: 0 requests the token and 1 withdraws the request. A withdrawn pending request never receives the token.
- R4: When a free token gets a request from one side only, that side holds it after the edge. It keeps the token, whatever the other side writes, until it writes a 1 to it. At most one side holds a token at any time.
- R5: When the holder writes 1 while the other side's latch holds 0, the other side holds the token from the very next cycle.
- R6: When the holder writes 1 and no request is pending, the token becomes free and both sides read all ones.
- R7: When both sides request a free token in the same cycle, the left side wins. Otherwise the side that requested earlier keeps priority.
- R8: A read returns one flag bit copied into all `DATA_W` (18) output bits. The flag is 0 when the reading side holds the token and 1 otherwise.
- R9: A side reads in a cycle where it has access (R2), `*_oe` is 1 and `*_wr` is 0. The token state before that edge is captured into `*_rdat` at the first such edge. `*_rdat` then holds that value while the read condition stays true, even if the token changes hands. In a cycle without a read, `*_rdat` becomes all ones.
- R10: After synchronous reset, all request latches hold 1, all tokens are free and both `*_rdat` outputs are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_mem_en | input | 1 | Left memory enable; 1 blocks bank access |
| lf_sem_en | input | 1 | Left semaphore select |
| lf_wr | input | 1 | Left write (1) or read (0) |
| lf_oe | input | 1 | Left output enable for reads |
| lf_idx | input | IDX_W | Left token index |
| lf_wbit | input | 1 | Left write value (0 request, 1 release) |
| lf_rdat | output | DATA_W | Left read flag, replicated |
| rt_mem_en | input | 1 | Right memory enable; 1 blocks bank access |
| rt_sem_en | input | 1 | Right semaphore select |
| rt_wr | input | 1 | Right write (1) or read (0) |
| rt_oe | input | 1 | Right output enable for reads |
| rt_idx | input | IDX_W | Right token index |
| rt_wbit | input | 1 | Right write value (0 request, 1 release) |
| rt_rdat | output | DATA_W | Right read flag, replicated |

## Verification
The assertions assume that every input is a clean synchronous level, free of X, and that each side presents a single access per cycle, which the port list already guarantees. They also assume that a side's read window is defined purely by its own select, memory enable, output enable and write pins. The bench changes every input only on the falling clock edge. It works through directed hand-over, withdrawal, tie and frozen-read sequences, then a pseudo-random phase that includes the illegal both-selects case. Every cycle's outputs are compared against a bench-side token model.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // one side's write request aimed at a single token
  typedef struct packed {
    logic wen;   // write strobe for this token
    logic wval;  // 0 = request, 1 = release
  } sem_wr_t;

  localparam int unsigned SEM_N_DFLT  = 8;
  localparam int unsigned SEM_DW_DFLT = 18;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  sem_wr_t l_req,
  input  sem_wr_t r_req,
  output logic    l_own,
  output logic    r_own
);
  logic l_lat, r_lat;       // request latches, 0 = wants token
  logic l_nxt, r_nxt;
  logic l_own_d, r_own_d;

  always_comb begin
    l_nxt = l_req.wen ? l_req.wval : l_lat;
    r_nxt = r_req.wen ? r_req.wval : r_lat;
  end

  always_comb begin
    l_own_d = l_own;
    r_own_d = r_own;
    if (l_own) begin
      if (l_nxt) begin
        l_own_d = 1'b0;
        r_own_d = ~r_nxt;
      end
    end else if (r_own) begin
      if (r_nxt) begin
        r_own_d = 1'b0;
        l_own_d = ~l_nxt;
      end
    end else begin
      l_own_d = ~l_nxt;            // left has priority on a tie
      r_own_d = l_nxt & ~r_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_lat <= 1'b1;
      r_lat <= 1'b1;
      l_own <= 1'b0;
      r_own <= 1'b0;
    end else begin
      l_lat <= l_nxt;
      r_lat <= r_nxt;
      l_own <= l_own_d;
      r_own <= r_own_d;
    end
  end

  AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({l_own, r_own})); // R4
  AST_HOLDER_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (l_own |-> !l_lat) and (r_own |-> !r_lat)); // R3
  AST_KEEP_TOKEN: assert property (@(posedge clk) disable iff (rst)
    (l_own && !(l_req.wen && l_req.wval)) |=> l_own); // R4
  AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (l_own && l_req.wen && l_req.wval && !r_lat && !r_req.wen) |=> r_own); // R5
  AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (rst)
    (r_own && r_req.wen && r_req.wval && l_lat && !l_req.wen) |=> (!l_own && !r_own)); // R6
  AST_TIE_LEFT: assert property (@(posedge clk) disable iff (rst)
    (!l_own && !r_own && l_req.wen && !l_req.wval && r_req.wen && !r_req.wval) |=> l_own); // R7
endmodule

// File: rtl/sem_port.sv
module sem_port
  import sem_pkg::*;
#(
  parameter int unsigned NUM_SEM = SEM_N_DFLT,
  parameter int unsigned IDX_W   = $clog2(NUM_SEM),
  parameter int unsigned DATA_W  = SEM_DW_DFLT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mem_en,
  input  logic               sem_en,
  input  logic               wr,
  input  logic               oe,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wbit,
  input  logic [NUM_SEM-1:0] own,
  output sem_wr_t            req [NUM_SEM],
  output logic [DATA_W-1:0]  rdat
);
  logic               acc, rd_act, rd_prev;
  logic [NUM_SEM-1:0] wen_v;

  assign acc    = sem_en & ~mem_en;
  assign rd_act = acc & oe & ~wr;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
    assign wen_v[g]    = acc & wr & (idx == IDX_W'(g));
    assign req[g].wen  = wen_v[g];
    assign req[g].wval = wbit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      rdat    <= '1;
    end else begin
      rd_prev <= rd_act;
      if (!rd_act)
        rdat <= '1;
      else if (!rd_prev)
        rdat <= {DATA_W{~own[idx]}};
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wen_v)); // R1
  AST_NO_ACCESS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(sem_en && !mem_en) |-> (wen_v == '0)); // R2
  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (rd_act && rd_prev) |=> $stable(rdat)); // R9
  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> (rdat == '1)); // R9
  AST_REPLICATED: assert property (@(posedge clk) disable iff (rst)
    (rdat == '0) || (rdat == '1)); // R8
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int unsigned NUM_SEM = SEM_N_DFLT,
  parameter int unsigned IDX_W   = $clog2(NUM_SEM),
  parameter int unsigned DATA_W  = SEM_DW_DFLT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lf_mem_en,
  input  logic              lf_sem_en,
  input  logic              lf_wr,
  input  logic              lf_oe,
  input  logic [IDX_W-1:0]  lf_idx,
  input  logic              lf_wbit,
  output logic [DATA_W-1:0] lf_rdat,
  input  logic              rt_mem_en,
  input  logic              rt_sem_en,
  input  logic              rt_wr,
  input  logic              rt_oe,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic              rt_wbit,
  output logic [DATA_W-1:0] rt_rdat
);
  sem_wr_t            l_req [NUM_SEM];
  sem_wr_t            r_req [NUM_SEM];
  logic [NUM_SEM-1:0] l_own_v, r_own_v;

  sem_port #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_lf (
    .clk(clk), .rst(rst), .mem_en(lf_mem_en), .sem_en(lf_sem_en), .wr(lf_wr),
    .oe(lf_oe), .idx(lf_idx), .wbit(lf_wbit), .own(l_own_v), .req(l_req),
    .rdat(lf_rdat));

  sem_port #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rt (
    .clk(clk), .rst(rst), .mem_en(rt_mem_en), .sem_en(rt_sem_en), .wr(rt_wr),
    .oe(rt_oe), .idx(rt_idx), .wbit(rt_wbit), .own(r_own_v), .req(r_req),
    .rdat(rt_rdat));

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell u_cell (
      .clk(clk), .rst(rst), .l_req(l_req[g]), .r_req(r_req[g]),
      .l_own(l_own_v[g]), .r_own(r_own_v[g]));
  end

  AST_NO_SHARED_TOKEN: assert property (@(posedge clk) disable iff (rst)
    (l_own_v & r_own_v) == '0); // R4
endmodule

// File: tb/sem_bank_test.sv
`timescale 1ns/1ps
module sem_bank_test;
  localparam int N  = 8;
  localparam int IW = 3;
  localparam int DW = 18;
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [DW-1:0] ZERO = '0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_me = 0, l_se = 0, l_wr = 0, l_oe = 0, l_wd = 1;
  logic r_me = 0, r_se = 0, r_wr = 0, r_oe = 0, r_wd = 1;
  logic [IW-1:0] l_ix = '0, r_ix = '0;
  logic [DW-1:0] l_rdat, r_rdat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench-side token model
  logic [N-1:0] ml_lat, mr_lat, mh_l, mh_r;
  logic [DW-1:0] el, er;
  logic lpv, rpv;

  always #2.5 clk = ~clk;

  sem_bank #(.NUM_SEM(N), .IDX_W(IW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst),
    .lf_mem_en(l_me), .lf_sem_en(l_se), .lf_wr(l_wr), .lf_oe(l_oe),
    .lf_idx(l_ix), .lf_wbit(l_wd), .lf_rdat(l_rdat),
    .rt_mem_en(r_me), .rt_sem_en(r_se), .rt_wr(r_wr), .rt_oe(r_oe),
    .rt_idx(r_ix), .rt_wbit(r_wd), .rt_rdat(r_rdat));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: update model from current inputs, compare at negedge
  task automatic step();
    logic lrd, rrd;
    logic [N-1:0] nl, nr;
    @(posedge clk);
    lrd = l_se & ~l_me & l_oe & ~l_wr;
    rrd = r_se & ~r_me & r_oe & ~r_wr;
    if (!lrd) el = ONES; else if (!lpv) el = {DW{~mh_l[l_ix]}};
    if (!rrd) er = ONES; else if (!rpv) er = {DW{~mh_r[r_ix]}};
    lpv = lrd; rpv = rrd;
    nl = ml_lat; nr = mr_lat;
    if (l_se & ~l_me & l_wr) nl[l_ix] = l_wd;
    if (r_se & ~r_me & r_wr) nr[r_ix] = r_wd;
    for (int i = 0; i < N; i++) begin
      if (mh_l[i]) begin
        if (nl[i]) begin mh_l[i] = 0; mh_r[i] = ~nr[i]; end
      end else if (mh_r[i]) begin
        if (nr[i]) begin mh_r[i] = 0; mh_l[i] = ~nl[i]; end
      end else begin
        mh_l[i] = ~nl[i];
        mh_r[i] = nl[i] & ~nr[i];
      end
    end
    ml_lat = nl; mr_lat = nr;
    @(negedge clk);
    chk("R9 left rdat vs model", l_rdat, el);
    chk("R9 right rdat vs model", r_rdat, er);
  endtask

  task automatic idle();
    l_me = 0; l_se = 0; l_wr = 0; l_oe = 0;
    r_me = 0; r_se = 0; r_wr = 0; r_oe = 0;
  endtask

  task automatic lwrite(input int ix, input logic v);
    idle(); l_se = 1; l_wr = 1; l_ix = IW'(ix); l_wd = v; step();
  endtask

  task automatic rwrite(input int ix, input logic v);
    idle(); r_se = 1; r_wr = 1; r_ix = IW'(ix); r_wd = v; step();
  endtask

  // read both sides once, then one idle cycle to close the window
  task automatic rd_both(input int li, input int ri, output logic [DW-1:0] lv, output logic [DW-1:0] rv);
    idle(); l_se = 1; l_oe = 1; l_ix = IW'(li); r_se = 1; r_oe = 1; r_ix = IW'(ri);
    step(); lv = l_rdat; rv = r_rdat;
    idle(); step();
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    logic [DW-1:0] a, b;
    logic [31:0] seed;
    ml_lat = '1; mr_lat = '1; mh_l = '0; mh_r = '0;
    el = ONES; er = ONES; lpv = 0; rpv = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10 left rdat after reset", l_rdat, ONES);
    chk("R10 right rdat after reset", r_rdat, ONES);
    rd_both(0, 7, a, b);
    chk("R10 token 0 free left", a, ONES);
    chk("R10 token 7 free right", b, ONES);

    // R1 R4: left takes token 3, neighbours untouched
    lwrite(3, 0);
    rd_both(3, 3, a, b);
    chk("R4 left owns 3", a, ZERO);
    chk("R8 right sees ones on 3", b, ONES);
    rd_both(2, 4, a, b);
    chk("R1 token 2 untouched", a, ONES);
    chk("R1 token 4 untouched", b, ONES);
    // right requests while left holds: cannot take
    rwrite(3, 0);
    rd_both(3, 3, a, b);
    chk("R4 left keeps 3", a, ZERO);
    chk("R4 right blocked on 3", b, ONES);
    // R5 handover
    lwrite(3, 1);
    rd_both(3, 3, a, b);
    chk("R5 left lost 3", a, ONES);
    chk("R5 right got 3", b, ZERO);
    // R6 release with nothing pending
    rwrite(3, 1);
    rd_both(3, 3, a, b);
    chk("R6 left free 3", a, ONES);
    chk("R6 right free 3", b, ONES);
    // R7 tie on 5
    idle(); l_se = 1; l_wr = 1; l_ix = 5; l_wd = 0;
    r_se = 1; r_wr = 1; r_ix = 5; r_wd = 0; step();
    rd_both(5, 5, a, b);
    chk("R7 tie left wins", a, ZERO);
    chk("R7 tie right loses", b, ONES);
    // R2: both selects -> no op; no select -> no op
    idle(); l_me = 1; l_se = 1; l_wr = 1; l_ix = 5; l_wd = 1; step();
    idle(); l_me = 0; l_se = 0; l_wr = 1; l_ix = 5; l_wd = 1; step();
    rd_both(5, 5, a, b);
    chk("R2 left still owns 5", a, ZERO);
    chk("R2 right still not 5", b, ONES);
    // R9: right pending on 5, right holds read open, left releases
    rwrite(5, 0);
    idle(); r_se = 1; r_oe = 1; r_ix = 5; step();
    chk("R9 right captured ones", r_rdat, ONES);
    l_se = 1; l_wr = 1; l_ix = 5; l_wd = 1; step();
    l_se = 0; l_wr = 0; step();
    chk("R9 right read frozen after handover", r_rdat, ONES);
    r_oe = 0; step();
    chk("R9 right idle ones", r_rdat, ONES);
    r_oe = 1; step();
    chk("R9 right re-read sees ownership", r_rdat, ZERO);
    idle(); step();
    // R3: withdrawn request gets nothing
    rwrite(5, 1);
    lwrite(6, 0);
    rwrite(6, 0);
    rwrite(6, 1);
    lwrite(6, 1);
    rd_both(6, 6, a, b);
    chk("R3 withdrawn left free 6", a, ONES);
    chk("R3 withdrawn right free 6", b, ONES);

    // sweep: every token, every pair of single-side actions
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 16; p++) begin
        idle();
        l_se = p[0]; l_wr = 1; l_ix = IW'(i); l_wd = p[1];
        r_se = p[2]; r_wr = 1; r_ix = IW'(i); r_wd = p[3];
        step();
        rd_both(i, i, a, b);
      end
    end

    // pseudo-random phase
    seed = 32'h1F3A_5C71;
    for (int k = 0; k < 4000; k++) begin
      seed = xs(seed);
      l_me = seed[0] & seed[1]; l_se = seed[2] | seed[3]; l_wr = seed[4];
      l_oe = seed[5]; l_ix = seed[8:6]; l_wd = seed[9];
      r_me = seed[10] & seed[11]; r_se = seed[12] | seed[13]; r_wr = seed[14];
      r_oe = seed[15]; r_ix = seed[18:16]; r_wd = seed[19];
      step();
    end
    idle(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule